// File: doc/BRIEF.md
# Address-Latching Byte Memory Cycle Controller

This block sits between a synchronous host and a 32K x 8 nonvolatile byte-wide memory. The memory captures its address on the falling edge of chip enable, and it needs a precharge interval with chip enable high after every access. The host issues one read or one write at a time over a valid/ready handshake. The controller turns each accepted request into a complete memory bus cycle. A cycle has three phases: setup, access and precharge. Parameters give the length of each phase in clock cycles.

In the setup phase the address is driven, and for a write so are write enable and the write data. Chip enable stays high during setup, so everything is stable before the address-latching edge. Chip enable then falls and stays low for the access count. A write therefore runs under chip-enable control: write enable is already low when chip enable falls, and both rise on the same clock edge. A read asserts output enable during the access phase only, and samples the bus in the last access cycle. It returns the byte with a one-cycle response pulse. After that the controller holds chip enable high for the precharge count. Only then does it raise ready again.

The data bus is given as separate output, output-enable and input pins. The pad ring combines them into the bidirectional bus.

Top module: `latch_mem_ctrl`

## Requirements
- R1: While rst_ni is low, req_ready_o is 1. mem_ce_no, mem_we_no and mem_oe_no are 1, and mem_dq_oe_o and rsp_valid_o are 0.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. mem_addr_o shows the accepted address from the next cycle until the next acceptance. Request inputs that change while a cycle is in progress have no effect on that cycle.
- R3: mem_ce_no is high for SETUP_CYC cycles after acceptance, then low for exactly ACCESS_CYC cycles, then high for at least PRECHARGE_CYC cycles. Between two falls of mem_ce_no there are at least SETUP_CYC + PRECHARGE_CYC high cycles.
- R4: In a read (req_write_i = 0), mem_oe_no is low exactly while mem_ce_no is low, and mem_we_no stays high. The byte on mem_dq_i in the last low cycle of mem_ce_no appears on rsp_rdata_o. In the first cycle after mem_ce_no rises, rsp_valid_o is 1 for exactly one cycle.
- R5: In a write (req_write_i = 1), mem_we_no is low from the cycle after acceptance through the last low cycle of mem_ce_no. It therefore falls before chip enable falls and rises on the same edge as chip enable. mem_oe_no stays high. mem_dq_o carries the accepted write byte for that whole interval.
- R6: mem_dq_oe_o is 1 only in write cycles, from setup through the last access cycle. It is never 1 while mem_oe_no is low.
- R7: req_ready_o is 0 from the cycle after acceptance for SETUP_CYC + ACCESS_CYC + PRECHARGE_CYC cycles, and 1 otherwise. A request held valid is accepted on the first edge after that interval.
- R8: A write produces no response pulse on rsp_valid_o.
- R9: A read issued immediately after a write, with no idle cycle, to the same address returns the byte just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 15 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle read data pulse |
| rsp_rdata_o | output | 8 | Read byte |
| mem_addr_o | output | 15 | Memory address pins |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data bus output value |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Data bus input value |

## Verification
The bench uses a memory model that latches its address only at the chip-enable fall. An address driven too late would therefore read or write the wrong location. The model drives a marker byte outside the output-enable window, so a read sampled at the wrong cycle is caught. Directed cases run a lone read, a write followed at once by a read of the same byte, and accesses at address 0 and at the top address. A random phase holds valid asserted while address, data and direction change every cycle, which separates correct capture at acceptance from late sampling of the request inputs. A second random phase leaves idle gaps between requests, which separates correct precharge and ready spacing from cycles that start early.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_PRECH
  } lmc_state_e;
endpackage

// File: rtl/lmc_seq.sv
module lmc_seq
  import lmc_pkg::*;
#(
  parameter int SETUP_CYC     = 1,
  parameter int ACCESS_CYC    = 4,
  parameter int PRECHARGE_CYC = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output lmc_state_e state_o,
  output logic       last_o
);
  localparam int MAX_CYC = (SETUP_CYC > ACCESS_CYC)
                           ? ((SETUP_CYC > PRECHARGE_CYC) ? SETUP_CYC : PRECHARGE_CYC)
                           : ((ACCESS_CYC > PRECHARGE_CYC) ? ACCESS_CYC : PRECHARGE_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  lmc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign state_o = state_q;
  assign last_o  = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SETUP;
          cnt_q   <= CNT_W'(SETUP_CYC - 1);
        end
        ST_SETUP: if (last_o) begin
          state_q <= ST_ACCESS;
          cnt_q   <= CNT_W'(ACCESS_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_ACCESS: if (last_o) begin
          state_q <= ST_PRECH;
          cnt_q   <= CNT_W'(PRECHARGE_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_PRECH: if (last_o) begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q - 1'b1;
        default: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  // R7: no new cycle can start outside idle
  a_r7_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q != ST_SETUP) || $past(state_q == ST_SETUP));
endmodule

// File: rtl/lmc_dpath.sv
module lmc_dpath
  import lmc_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int SETUP_CYC     = 1,
  parameter int ACCESS_CYC    = 4,
  parameter int PRECHARGE_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  lmc_state_e        state_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  localparam int GAP   = SETUP_CYC + PRECHARGE_CYC;
  localparam int GAP_W = $clog2(GAP + 1);
  localparam int ACC_W = $clog2(ACCESS_CYC + 1);

  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              in_setup, in_access, wr_window;

  assign in_setup  = (state_i == ST_SETUP);
  assign in_access = (state_i == ST_ACCESS);
  assign wr_window = wr_q && (in_setup || in_access);

  // request captured once; inputs ignored afterwards
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start_i) begin
      wr_q    <= req_write_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  // read byte taken in the last access cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= in_access && last_i && !wr_q;
      if (in_access && last_i && !wr_q) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_ce_no   = !in_access;
  assign mem_we_no   = !wr_window;   // low before CE falls: CE-controlled write
  assign mem_oe_no   = !(!wr_q && in_access);
  assign mem_dq_oe_o = wr_window;
  assign mem_dq_o    = wdata_q;
  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;

  // run-length counters for pin timing checks
  logic [GAP_W-1:0] hi_cnt_q;
  logic [ACC_W-1:0] lo_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= GAP_W'(GAP);
      lo_cnt_q <= '0;
    end else if (mem_ce_no) begin
      lo_cnt_q <= '0;
      if (hi_cnt_q < GAP_W'(GAP)) hi_cnt_q <= hi_cnt_q + 1'b1;
    end else begin
      hi_cnt_q <= '0;
      if (lo_cnt_q < ACC_W'(ACCESS_CYC)) lo_cnt_q <= lo_cnt_q + 1'b1;
    end
  end

  a_r3_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> (hi_cnt_q == GAP_W'(GAP)));
  a_r3_access_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |-> (lo_cnt_q == ACC_W'(ACCESS_CYC)));
  a_r2_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> $stable(mem_addr_o));
  a_r5_we_before_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> $stable(mem_we_no));
  a_r5_write_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_ce_no) && $past(!mem_we_no)) |-> (mem_we_no && $past(mem_dq_oe_o)));
  a_r6_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_no));
  a_r4_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r8_rsp_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($past(!mem_oe_no) && mem_ce_no));
endmodule

// File: rtl/latch_mem_ctrl.sv
module latch_mem_ctrl
  import lmc_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int SETUP_CYC     = 1,
  parameter int ACCESS_CYC    = 4,
  parameter int PRECHARGE_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  lmc_state_e state;
  logic       last;
  logic       start;

  assign req_ready_o = (state == ST_IDLE);
  assign start       = req_valid_i && req_ready_o;

  lmc_seq #(
    .SETUP_CYC    (SETUP_CYC),
    .ACCESS_CYC   (ACCESS_CYC),
    .PRECHARGE_CYC(PRECHARGE_CYC)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .state_o(state),
    .last_o (last)
  );

  lmc_dpath #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .SETUP_CYC    (SETUP_CYC),
    .ACCESS_CYC   (ACCESS_CYC),
    .PRECHARGE_CYC(PRECHARGE_CYC)
  ) u_dpath (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .state_i    (state),
    .last_i     (last),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_ce_no  (mem_ce_no),
    .mem_we_no  (mem_we_no),
    .mem_oe_no  (mem_oe_no),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o),
    .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o)
  );

  a_r7_busy_while_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> !req_ready_o);
  a_r7_busy_on_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
endmodule

// File: tb/sim_latch_mem_ctrl.sv
`timescale 1ns/1ps
module sim_latch_mem_ctrl;
  localparam int S = 1, A = 4, P = 3;
  localparam int TOT = S + A + P;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [14:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [7:0]  rsp_rdata_o;
  logic [14:0] mem_addr_o;
  logic        mem_ce_no, mem_we_no, mem_oe_no, mem_dq_oe_o;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'hA5;

  always #5 clk_i = ~clk_i;

  latch_mem_ctrl #(.SETUP_CYC(S), .ACCESS_CYC(A), .PRECHARGE_CYC(P)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .mem_addr_o(mem_addr_o),
    .mem_ce_no(mem_ce_no), .mem_we_no(mem_we_no), .mem_oe_no(mem_oe_no),
    .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i));

  int checks = 0, errs = 0;
  logic [7:0] dev_mem [int];
  logic [7:0] ref_mem [int];
  logic [14:0] dev_addr = '0;
  logic        prev_ce = 1'b1;
  bit          busy = 0, m_wr = 0;
  int          t = 0;
  logic [14:0] m_addr = '0;
  logic [7:0]  m_wd = '0;
  logic [7:0]  last_rsp = '0;

  function automatic logic [7:0] init_val(logic [14:0] a);
    return 8'(a) ^ 8'(a >> 7) ^ 8'h3C;
  endfunction
  function automatic logic [7:0] dev_rd(logic [14:0] a);
    return dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : init_val(a);
  endfunction
  function automatic logic [7:0] ref_rd(logic [14:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
  endfunction

  task automatic ck(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // device model and per-cycle comparison, run at negedge
  task automatic compare_cycle();
    bit acc_ph, e_ce, e_we, e_oe, e_dqoe, e_rv;
    acc_ph = busy && t >= S && t < S + A;
    e_ce   = !acc_ph;
    e_we   = !(busy && m_wr && t < S + A);
    e_oe   = !(busy && !m_wr && acc_ph);
    e_dqoe = busy && m_wr && t < S + A;
    e_rv   = busy && !m_wr && t == S + A;
    if (prev_ce && !mem_ce_no) dev_addr = mem_addr_o;
    prev_ce = mem_ce_no;
    if (!mem_ce_no && !mem_we_no && mem_dq_oe_o) dev_mem[int'(dev_addr)] = mem_dq_o;
    mem_dq_i = (!mem_ce_no && !mem_oe_no) ? dev_rd(dev_addr) : 8'hA5;
    ck("R7 ready", req_ready_o, !busy);
    ck("R3 ce_n", mem_ce_no, e_ce);
    ck("R5 we_n", mem_we_no, e_we);
    ck("R4 oe_n", mem_oe_no, e_oe);
    ck("R6 dq_oe", mem_dq_oe_o, e_dqoe);
    if (busy) ck("R2 addr", mem_addr_o, m_addr);
    if (e_dqoe) ck("R5 wdata", mem_dq_o, m_wd);
    ck(m_wr ? "R8 rsp_valid" : "R4 rsp_valid", rsp_valid_o, e_rv);
    if (e_rv) begin
      ck("R4 rdata", rsp_rdata_o, ref_rd(m_addr));
      last_rsp = rsp_rdata_o;
    end
  endtask

  task automatic step(bit v, bit w, logic [14:0] a, logic [7:0] d);
    req_valid_i = v; req_write_i = w; req_addr_i = a; req_wdata_i = d;
    @(posedge clk_i);
    if (busy) begin
      t++;
      if (t == TOT) busy = 0;
    end else if (v) begin
      busy = 1; t = 0; m_wr = w; m_addr = a; m_wd = d;
      if (w) ref_mem[int'(a)] = d;
    end
    @(negedge clk_i);
    compare_cycle();
  endtask

  task automatic issue(bit w, logic [14:0] a, logic [7:0] d);
    bit acc;
    forever begin
      acc = req_ready_o;
      step(1'b1, w, a, d);
      if (acc) break;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'($urandom), 15'($urandom), 8'($urandom));
  endtask

  initial begin
    #(200000 * 10);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    ck("R1 ready", req_ready_o, 1'b1);
    ck("R1 ce_n", mem_ce_no, 1'b1);
    ck("R1 we_n", mem_we_no, 1'b1);
    ck("R1 oe_n", mem_oe_no, 1'b1);
    ck("R1 dq_oe", mem_dq_oe_o, 1'b0);
    ck("R1 rsp_valid", rsp_valid_o, 1'b0);
    rst_ni = 1'b1;
    idle(3);
    issue(1'b0, 15'h0123, 8'h00);
    idle(TOT + 2);
    // R9 write then immediate read of same byte
    issue(1'b1, 15'h0123, 8'hC3);
    issue(1'b0, 15'h0123, 8'h00);
    idle(TOT + 1);
    ck("R9 read after write", last_rsp, 8'hC3);
    issue(1'b1, 15'h0000, 8'h81);
    issue(1'b1, 15'h7FFF, 8'h7E);
    issue(1'b0, 15'h0000, 8'h00);
    idle(TOT + 1);
    ck("R9 low address", last_rsp, 8'h81);
    issue(1'b0, 15'h7FFF, 8'h00);
    idle(TOT + 1);
    ck("R4 top address", last_rsp, 8'h7E);
    // R2: valid held, inputs changing every cycle
    for (int i = 0; i < 1500; i++)
      step(1'b1, 1'($urandom), 15'($urandom_range(0, 31)), 8'($urandom));
    // idle gaps between requests
    for (int i = 0; i < 1500; i++)
      step(1'($urandom_range(0, 3) == 0), 1'($urandom), 15'($urandom_range(0, 31)), 8'($urandom));
    idle(TOT + 2);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule